// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that accepts a read or a write on every enabled clock edge with no idle cycles between them, in any mix. Address, controls, chip selects and lane write selects are all captured on the rising clock edge. A read returns its word in the cycle right after its address edge, with no output register in the path. A write takes its data one edge after its address. That data is held in a pending-write register and is committed to the word array only when the next write data arrives. A read that hits the pending address takes the enabled lanes from the pending register, so later reads always see the newest data.

A two-bit burst counter lets a host issue one full address and then step through the other three words of the aligned group of four. The step order is either linear, counting up and wrapping modulo four, or interleaved, where the start offset is XORed with the step count. A clock-enable input freezes the whole pipeline for a cycle. Three chip selects, an asynchronous output enable and a sleep input decide whether the block drives the bus at all. The bidirectional data bus is modelled as an input word, an output word and an output-drive flag.

Top module: `zbt_flow_sram`

## Requirements
- R1: After a synchronous active-low reset, `dq_oe` is 0 and no operation is in progress.
- R2: A read registered at edge n drives `dq_oe`=1 and the addressed word on `dq_out` in the cycle between edge n and edge n+1.
- R3: The block is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. On a load cycle any other pattern starts no operation: `dq_oe` stays 0 and nothing is written.
- R4: A write takes its data from `dq_in` at the enabled edge after its address edge. Lane i is bits [9i+8:9i]. It is written only when `lane_wr_n[i]`=0 in the address cycle; the other lanes keep their old contents.
- R5: Reads and writes may alternate on consecutive edges. During the data phase of a write (the cycle after its address edge), `dq_oe` is 0.
- R6: A read of an address whose write is still pending returns the new data for the lanes that write enabled and the stored data for the others.
- R7: With `burst_adv`=1 after a selected load, the operation type is kept. The two low address bits become (start + step) mod 4 when the load had `order_ilv`=0.
- R8: When the load had `order_ilv`=1, the two low address bits during the burst are start XOR step. The order is fixed at the load cycle.
- R9: An edge with `clk_en`=0 is ignored: outputs hold, no write is performed, and a pending data phase moves to the next enabled edge.
- R10: `oe_n`=1 forces `dq_oe` to 0 in the same cycle, regardless of the clock.
- R11: `burst_adv`=1 while no operation is active (after a deselect) is ignored, and `dq_oe` stays 0.
- R12: While `sleep`=1, `dq_oe` is 0 and enabled edges start no operation. After `sleep` returns to 0, the outputs stay high-Z until a new selected read is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | 1 = act on this edge, 0 = ignore the edge |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| burst_adv | input | 1 | 1 = step the burst, 0 = load a new address |
| wr_n | input | 1 | 0 = write, 1 = read (on load cycles) |
| addr | input | AW | Word address |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| order_ilv | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| dq_in | input | LANES*LW | Write data from the bus |
| dq_out | output | LANES*LW | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions check the output-drive rules on every cycle: an inactive output enable or an asserted sleep keeps the bus undriven, a deselecting load or a write address leaves the following cycle undriven, and an ignored edge leaves both the drive flag and the read word unchanged. Data content needs a reference, so only the bench scenarios can show it. These scenarios cover write-then-read bypass through the pending register, partial-lane merges, linear and interleaved burst address order, a stalled data phase that must not capture the bus, and writes attempted while deselected.

// File: rtl/zbt_pkg.sv
// Package: shared operation type and burst address helper for the
// flow-through SRAM. Assumes a burst group of four words.
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits for a burst step, linear or interleaved.
    function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       ilv);
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/zbt_burst_ctl.sv
// Module: operation and burst tracker. Registers the operation type and
// start address on a selected load, steps a 2-bit counter on advance and
// returns to idle on deselect or sleep. Assumes AW >= 3 and that all
// updates are gated by the clock enable.
module zbt_burst_ctl
    import zbt_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          sleep,
    input  logic          sel_ok,
    input  logic          burst_adv,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic          order_ilv,
    output op_e           op,
    output logic [AW-1:0] op_addr
);

    logic [AW-1:0] base_q;
    logic [1:0]    step_q;
    logic          ilv_q;

    // Track the current operation, its start address and the burst step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op     <= OP_IDLE;
            base_q <= '0;
            step_q <= '0;
            ilv_q  <= 1'b0;
        end else if (clk_en) begin
            if (sleep) begin
                op <= OP_IDLE;
            end else if (burst_adv) begin
                if (op != OP_IDLE) begin
                    step_q <= step_q + 2'd1;
                end
            end else if (sel_ok) begin
                op     <= wr_n ? OP_READ : OP_WRITE;
                base_q <= addr;
                step_q <= 2'd0;
                ilv_q  <= order_ilv;
            end else begin
                op <= OP_IDLE;
            end
        end
    end

    // Form the word address of the current burst step.
    always_comb begin
        op_addr = {base_q[AW-1:2], burst_lsb(base_q[1:0], step_q, ilv_q)};
    end

endmodule

// File: rtl/zbt_wr_registry.sv
// Module: late-write registry and word array. Captures write data one
// enabled edge after its address into a pending register, commits the
// previous pending write to the array at the same time, and merges the
// pending lanes into reads that hit its address. Assumes that commit_req
// is asserted only during a write data phase.
module zbt_wr_registry #(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                commit_req,
    input  logic [AW-1:0]       req_addr,
    input  logic [LANES-1:0]    req_lanes,
    input  logic [LANES*LW-1:0] din,
    input  logic [AW-1:0]       rd_addr,
    output logic [LANES*LW-1:0] rd_data
);

    localparam int DW    = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic             pend_v;
    logic [AW-1:0]    pend_a;
    logic [LANES-1:0] pend_m;
    logic [DW-1:0]    pend_d;
    logic [DW-1:0]    mem_word;
    logic             hit;

    // Load the pending-write register with the arriving data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_a <= '0;
            pend_m <= '0;
            pend_d <= '0;
        end else if (clk_en && commit_req) begin
            pend_v <= 1'b1;
            pend_a <= req_addr;
            pend_m <= req_lanes;
            pend_d <= din;
        end
    end

    // Retire the older pending write into the array, lane by lane.
    always_ff @(posedge clk) begin
        if (clk_en && commit_req && pend_v) begin
            for (int l = 0; l < LANES; l++) begin
                if (pend_m[l]) begin
                    mem[pend_a][l*LW +: LW] <= pend_d[l*LW +: LW];
                end
            end
        end
    end

    // Look up the array and detect a hit on the pending address.
    always_comb begin
        mem_word = mem[rd_addr];
        hit      = pend_v && (pend_a == rd_addr);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_data[g*LW +: LW] = (hit && pend_m[g]) ? pend_d[g*LW +: LW]
                                                        : mem_word[g*LW +: LW];
    end

endmodule

// File: rtl/zbt_flow_sram.sv
// Module: top of the zero-turnaround flow-through SRAM. Decodes the chip
// selects, registers the lane write selects with each address, ties the
// burst tracker to the late-write registry and gates the bus drive.
// Assumes the host holds write data for the edge after the address edge.
module zbt_flow_sram
    import zbt_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                sel1_n,
    input  logic                sel2,
    input  logic                sel3_n,
    input  logic                burst_adv,
    input  logic                wr_n,
    input  logic [AW-1:0]       addr,
    input  logic [LANES-1:0]    lane_wr_n,
    input  logic                order_ilv,
    input  logic                oe_n,
    input  logic                sleep,
    input  logic [LANES*LW-1:0] dq_in,
    output logic [LANES*LW-1:0] dq_out,
    output logic                dq_oe
);

    localparam int DW = LANES * LW;

    logic             sel_ok;
    op_e              op;
    logic [AW-1:0]    op_addr;
    logic [LANES-1:0] lane_q;
    logic [DW-1:0]    rd_word;

    // Decode the three chip selects.
    always_comb begin
        sel_ok = !sel1_n && sel2 && !sel3_n;
    end

    // Register the lane enables alongside the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else if (clk_en) begin
            lane_q <= ~lane_wr_n;
        end
    end

    zbt_burst_ctl #(.AW(AW)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .sleep     (sleep),
        .sel_ok    (sel_ok),
        .burst_adv (burst_adv),
        .wr_n      (wr_n),
        .addr      (addr),
        .order_ilv (order_ilv),
        .op        (op),
        .op_addr   (op_addr)
    );

    zbt_wr_registry #(.AW(AW), .LANES(LANES), .LW(LW)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .commit_req (op == OP_WRITE),
        .req_addr   (op_addr),
        .req_lanes  (lane_q),
        .din        (dq_in),
        .rd_addr    (op_addr),
        .rd_data    (rd_word)
    );

    // Drive the bus only for a read with output enable active and awake.
    always_comb begin
        dq_oe  = (op == OP_READ) && !oe_n && !sleep;
        dq_out = dq_oe ? rd_word : '0;
    end

endmodule

// File: rtl/zbt_sram_chk.sv
// Module: assertion checker for zbt_flow_sram, attached with bind.
// Assumes it sees the top-level ports only.
module zbt_sram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          sel1_n,
    input logic          sel2,
    input logic          sel3_n,
    input logic          burst_adv,
    input logic          wr_n,
    input logic          oe_n,
    input logic          sleep,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe
);

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);

    p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !burst_adv && !sleep && !(!sel1_n && sel2 && !sel3_n))
        |=> !dq_oe);

    p_wr_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !burst_adv && !sleep && !sel1_n && sel2 && !sel3_n && !wr_n)
        |=> !dq_oe);

    p_stall_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!clk_en) && $past(rst_n) && $stable(oe_n) && $stable(sleep))
        |-> $stable(dq_oe));

    p_stall_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!clk_en) && $past(rst_n) && $stable(oe_n) && $stable(sleep) && dq_oe)
        |-> $stable(dq_out));

endmodule

bind zbt_flow_sram zbt_sram_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .burst_adv (burst_adv),
    .wr_n      (wr_n),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
);

// File: tb/sim_zbt_flow_sram.sv
module sim_zbt_flow_sram;

    localparam int AW = 8;
    localparam int DW = 36;
    localparam time T = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
    logic          burst_adv = 1'b0, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [3:0]    lane_wr_n = 4'hF;
    logic          order_ilv = 1'b0, oe_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    zbt_flow_sram #(.AW(AW), .LANES(4), .LW(9)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .burst_adv(burst_adv), .wr_n(wr_n), .addr(addr),
        .lane_wr_n(lane_wr_n), .order_ilv(order_ilv), .oe_n(oe_n),
        .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #(T/2) clk = ~clk;

    typedef struct {
        bit            hiz;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t q[$];
    exp_t last_e;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    // Reference model state, built from the requirements.
    logic [DW-1:0] sh [1<<AW];
    int            m_op = 0;          // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    bit            m_ilv = 1'b0;
    bit            m_wp = 1'b0;
    logic [AW-1:0] m_wa = '0;
    logic [3:0]    m_wm = '0;
    logic [DW-1:0] wd_next = '0;

    task automatic cyc(input bit en, input bit s1n, input bit s2, input bit s3n,
                       input bit adv, input bit wrn, input logic [AW-1:0] a,
                       input logic [3:0] lwn, input bit md, input bit oen,
                       input bit slp, input bit garb, input logic [DW-1:0] nd,
                       input string tag);
        exp_t          e;
        logic [AW-1:0] ea;
        @(negedge clk);
        clk_en = en; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
        burst_adv = adv; wr_n = wrn; addr = a; lane_wr_n = lwn;
        order_ilv = md; oe_n = oen; sleep = slp;
        dq_in = garb ? ~wd_next : wd_next;
        if (!en) begin
            e = last_e;
            e.tag = tag;
        end else begin
            if (m_wp) begin
                for (int l = 0; l < 4; l++)
                    if (m_wm[l]) sh[m_wa][l*9 +: 9] = wd_next[l*9 +: 9];
                m_wp = 1'b0;
            end
            if (slp) m_op = 0;
            else if (adv) begin
                if (m_op != 0) m_cnt = m_cnt + 2'd1;
            end else if (!s1n && s2 && !s3n) begin
                m_op = wrn ? 1 : 2; m_base = a; m_cnt = 2'd0; m_ilv = md;
            end else m_op = 0;
            ea = {m_base[AW-1:2], m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
            if (m_op == 2) begin
                m_wp = 1'b1; m_wa = ea; m_wm = ~lwn;
            end
            e.hiz = !(m_op == 1 && !oen && !slp);
            e.d   = e.hiz ? '0 : sh[ea];
            e.tag = tag;
            wd_next = nd;
        end
        last_e = e;
        q.push_back(e);
    endtask

    task automatic rd(input logic [AW-1:0] a, input bit md, input string tag);
        cyc(1, 0, 1, 0, 0, 1, a, 4'hF, md, 0, 0, 0, '0, tag);
    endtask
    task automatic wr(input logic [AW-1:0] a, input logic [3:0] lwn,
                      input logic [DW-1:0] d, input string tag);
        cyc(1, 0, 1, 0, 0, 0, a, lwn, 0, 0, 0, 0, d, tag);
    endtask
    task automatic wrm(input logic [AW-1:0] a, input bit md,
                       input logic [DW-1:0] d, input string tag);
        cyc(1, 0, 1, 0, 0, 0, a, 4'h0, md, 0, 0, 0, d, tag);
    endtask
    task automatic adv(input logic [3:0] lwn, input logic [DW-1:0] d, input string tag);
        cyc(1, 0, 1, 0, 1, 1, '0, lwn, 0, 0, 0, 0, d, tag);
    endtask
    task automatic stl(input bit garb, input string tag);
        cyc(0, 0, 1, 0, 0, 1, '0, 4'hF, 0, 0, 0, garb, '0, tag);
    endtask
    task automatic ds(input string tag);
        cyc(1, 1, 1, 0, 0, 1, '0, 4'hF, 0, 0, 0, 0, '0, tag);
    endtask

    // Scoreboard monitor: compare each cycle's output against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (e.hiz) begin
                    if (dq_oe !== 1'b0) begin
                        bad++;
                        $display("FAIL %s: dq_oe=%b expected 0", e.tag, dq_oe);
                    end
                end else if (dq_oe !== 1'b1 || dq_out !== e.d) begin
                    bad++;
                    $display("FAIL %s: dq_oe=%b dq_out=%h expected oe=1 data=%h",
                             e.tag, dq_oe, dq_out, e.d);
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(T * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        last_e.hiz = 1'b1; last_e.d = '0; last_e.tag = "";
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (dq_oe !== 1'b0) begin
            bad++;
            $display("FAIL R1: dq_oe=%b expected 0 in reset", dq_oe);
        end
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (dq_oe !== 1'b0) begin
            bad++;
            $display("FAIL R1: dq_oe=%b expected 0 after reset", dq_oe);
        end

        // R2 R4 R5 R6: alternating writes and reads with bypass.
        wr(8'h10, 4'h0, 36'h1_2345_6789, "R5_wr");
        rd(8'h10, 0, "R6_bypass_full");
        wr(8'h20, 4'h0, 36'hA_BCDE_F012, "R5_wr2");
        rd(8'h10, 0, "R2_read");
        rd(8'h20, 0, "R6_pending_hit");
        wr(8'h10, 4'b1010, 36'hF_FFFF_FFFF, "R4_partial");
        rd(8'h10, 0, "R4_merge");
        rd(8'h20, 0, "R2_read2");
        rd(8'h10, 0, "R4_after_commit");

        // R7 linear write burst, R8 interleaved read burst.
        wrm(8'h41, 0, 36'h0_0000_0041, "R7_wr_load");
        adv(4'h0, 36'h0_0000_0042, "R7_wr_adv1");
        adv(4'h0, 36'h0_0000_0043, "R7_wr_adv2");
        adv(4'h0, 36'h0_0000_0040, "R7_wr_adv3");
        rd(8'h41, 1, "R8_ilv0");
        adv(4'hF, '0, "R8_ilv1");
        adv(4'hF, '0, "R8_ilv2");
        adv(4'hF, '0, "R8_ilv3");
        rd(8'h42, 0, "R7_lin0");
        adv(4'hF, '0, "R7_lin1");
        adv(4'hF, '0, "R7_lin2");
        adv(4'hF, '0, "R7_lin3");
        wrm(8'h46, 1, 36'h5_5555_5555, "R8_wr_ilv");
        adv(4'h0, 36'h6_6666_6666, "R8_wr_ilv1");
        rd(8'h47, 0, "R8_wr_chk");
        rd(8'h46, 0, "R8_wr_chk0");

        // R9 stalls: output held, stalled data phase captures nothing.
        rd(8'h20, 0, "R9_pre");
        stl(0, "R9_hold1");
        stl(1, "R9_hold2");
        wr(8'h30, 4'h0, 36'h3_3333_3333, "R9_wr");
        stl(1, "R9_stall_data");
        rd(8'h30, 0, "R9_no_garbage");
        rd(8'h30, 0, "R9_again");

        // R3 deselect patterns and a write that must not land.
        cyc(1, 1, 1, 0, 0, 1, 8'h10, 4'hF, 0, 0, 0, 0, '0, "R3_sel1");
        cyc(1, 0, 0, 0, 0, 1, 8'h10, 4'hF, 0, 0, 0, 0, '0, "R3_sel2");
        cyc(1, 0, 1, 1, 0, 1, 8'h10, 4'hF, 0, 0, 0, 0, '0, "R3_sel3");
        cyc(1, 0, 0, 0, 0, 0, 8'h20, 4'h0, 0, 0, 0, 0, 36'h0_DEAD_0000, "R3_wr_desel");
        rd(8'h20, 0, "R3_no_write");

        // R11 advance after deselect.
        ds("R11_ds");
        adv(4'hF, '0, "R11_adv");
        adv(4'h0, 36'h0_BAD0_0000, "R11_adv2");
        rd(8'h20, 0, "R11_no_write");

        // R10 output enable.
        cyc(1, 0, 1, 0, 0, 1, 8'h41, 4'hF, 0, 1, 0, 0, '0, "R10_oe_off");
        cyc(1, 0, 1, 0, 1, 1, 8'h00, 4'hF, 0, 0, 0, 0, '0, "R10_oe_on");

        // R12 sleep.
        ds("R12_ds");
        cyc(1, 0, 1, 0, 0, 1, 8'h10, 4'hF, 0, 0, 1, 0, '0, "R12_sleep_rd");
        cyc(1, 0, 1, 0, 0, 1, 8'h20, 4'hF, 0, 0, 1, 0, '0, "R12_sleep_rd2");
        adv(4'hF, '0, "R12_wake_adv");
        rd(8'h20, 0, "R12_wake_rd");
        ds("end");

        @(posedge clk);
        #10;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule